// File: doc/BRIEF.md
# Mixed-Decay Fixed Off-Time Current Chopper

This block sequences the four switches of one H-bridge so that the winding current is held near a limit. While the bridge drives a diagonal pair, a digital trip flag from an external sense comparator reports that the current has reached its limit. Once a blanking window at the start of the drive phase has passed, a trip starts a fixed off-time. The first half of that off-time is fast decay, in which the opposite diagonal conducts. The second half is slow decay, in which both low-side switches conduct. After the off-time the bridge returns to diagonal drive and blanking starts again.

All switches are forced off for a crossover gap whenever the switch pattern changes. During decay the switches that conduct act as synchronous rectifiers. A zero-current flag turns them off for the rest of the off-time, so the load current cannot reverse. A coast, brake or direction request takes effect at once in any phase. Only the crossover gap is kept before the new pattern appears. All durations are parameters counted in clock cycles.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all four gates are off and `busy` is low.
- R2: With `drive_en` low, all gates are off (coast). With `drive_en` and `brake_req` both high, only `ls_a` and `ls_b` are on (brake). With `drive_en` high and `brake_req` low, the drive phase turns on `hs_a` and `ls_b` when `dir_fwd` is 1, and `hs_b` and `ls_a` when `dir_fwd` is 0.
- R3: Every change from one switch pattern to another passes through exactly `T_DEAD` cycles with all gates off. Two different non-zero patterns never appear in consecutive cycles.
- R4: During the first `T_BLANK` cycles of each drive phase, `trip` has no effect and the drive pattern is held.
- R5: A `trip` sampled high after blanking is followed by the crossover gap, and then by `T_OFF/2` cycles of fast decay. Fast decay turns on the opposite diagonal: `hs_b`+`ls_a` for forward, `hs_a`+`ls_b` for reverse.
- R6: Fast decay is followed by the crossover gap, and then by `T_OFF - T_OFF/2` cycles of slow decay with `ls_a` and `ls_b` on.
- R7: Slow decay is followed by the crossover gap, and then by drive in the stored direction, with a fresh blanking window.
- R8: When `zero_cur` is sampled high during fast or slow decay, all gates are off from the next cycle until the next drive phase starts.
- R9: A change of request during drive, decay or a crossover gap starts (or keeps) the crossover gap at once. When the gap ends, the pattern of the latest request follows.
- R10: `busy` is high during fast decay, slow decay and the crossover gap that leads into each of them, and low otherwise. It always rises while all gates are off.
- R11: `hs_a` and `ls_a` are never on together, and neither are `hs_b` and `ls_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drive_en | input | 1 | 1 = bridge active, 0 = coast |
| brake_req | input | 1 | With drive_en high: 1 = brake with both low sides on |
| dir_fwd | input | 1 | Drive direction, 1 = forward (A high, B low) |
| trip | input | 1 | Current limit reached |
| zero_cur | input | 1 | Winding current has decayed to zero |
| hs_a | output | 1 | High-side gate, leg A |
| ls_a | output | 1 | Low-side gate, leg A |
| hs_b | output | 1 | High-side gate, leg B |
| ls_b | output | 1 | Low-side gate, leg B |
| busy | output | 1 | Off-time in progress |

## Verification
Two events can fall in the same cycle: the end of a timed phase and an external event. One case is a trip that arrives in the very cycle blanking expires. The other is a brake, coast or reversal request that lands on the last cycle of fast or slow decay, or inside a crossover gap. The bench sweeps the trip pulse across the blanking boundary, and sweeps the request change across every offset of a full chop period. The expected gate pattern and `busy` come from a behavioural model, and the bench compares them with the outputs on every cycle. The expected result is that the request wins: the gap is entered, or kept, and its target is replaced.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_BRAKE,
        PH_DRIVE,
        PH_FAST,
        PH_SLOW,
        PH_DEAD
    } phase_t;

    // gate vector order: {hs_a, ls_a, hs_b, ls_b}
    localparam logic [3:0] GV_NONE  = 4'b0000;
    localparam logic [3:0] GV_LOWS  = 4'b0101;
    localparam logic [3:0] GV_DIAGA = 4'b1001;
    localparam logic [3:0] GV_DIAGB = 4'b0110;

    function automatic logic in_motion(phase_t p);
        return (p == PH_DRIVE) || (p == PH_FAST) || (p == PH_SLOW);
    endfunction

    // true when the held activity already satisfies the request
    function automatic logic req_kept(phase_t held, logic held_fwd,
                                      phase_t want, logic want_fwd);
        if (in_motion(held))
            return (want == PH_DRIVE) && (want_fwd == held_fwd);
        return want == held;
    endfunction

endpackage

// File: rtl/chop_req_decode.sv
module chop_req_decode
    import chop_pkg::*;
(
    input  logic   drive_en,
    input  logic   brake_req,
    output phase_t req_ph
);
    always_comb begin
        if (!drive_en)
            req_ph = PH_OFF;
        else if (brake_req)
            req_ph = PH_BRAKE;
        else
            req_ph = PH_DRIVE;
    end
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  phase_t     ph,
    input  logic       fwd,
    input  logic       zc_cut,
    output logic [3:0] gates
);
    always_comb begin
        case (ph)
            PH_BRAKE: gates = GV_LOWS;
            PH_DRIVE: gates = fwd ? GV_DIAGA : GV_DIAGB;
            PH_FAST:  gates = zc_cut ? GV_NONE : (fwd ? GV_DIAGB : GV_DIAGA);
            PH_SLOW:  gates = zc_cut ? GV_NONE : GV_LOWS;
            default:  gates = GV_NONE;
        endcase
    end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int T_DEAD  = 25,
    parameter int T_BLANK = 750,
    parameter int T_OFF   = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic brake_req,
    input  logic dir_fwd,
    input  logic trip,
    input  logic zero_cur,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b,
    output logic busy
);
    localparam int T_FAST  = T_OFF / 2;
    localparam int T_SLOW  = T_OFF - T_FAST;
    localparam int T_BIG   = (T_BLANK > T_OFF) ? T_BLANK : T_OFF;
    localparam int T_MAX   = (T_BIG > T_DEAD) ? T_BIG : T_DEAD;
    localparam int CW      = $clog2(T_MAX + 1);
    localparam logic [CW-1:0] C_DEAD  = CW'(T_DEAD - 1);
    localparam logic [CW-1:0] C_BLANK = CW'(T_BLANK);
    localparam logic [CW-1:0] C_FAST  = CW'(T_FAST - 1);
    localparam logic [CW-1:0] C_SLOW  = CW'(T_SLOW - 1);

    typedef struct packed {
        phase_t        ph;
        phase_t        tgt;
        logic          fwd;
        logic          zc;
        logic [CW-1:0] cnt;
    } st_t;

    localparam st_t ST_RESET = '{ph: PH_OFF, tgt: PH_OFF, fwd: 1'b0,
                                 zc: 1'b0, cnt: '0};

    st_t        s_q, s_d;
    phase_t     req_ph;
    logic [3:0] gates;

    chop_req_decode u_req (
        .drive_en  (drive_en),
        .brake_req (brake_req),
        .req_ph    (req_ph)
    );

    function automatic logic [CW-1:0] entry_count(phase_t p);
        case (p)
            PH_DRIVE: return C_BLANK;
            PH_FAST:  return C_FAST;
            PH_SLOW:  return C_SLOW;
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        s_d = s_q;
        if ((s_q.ph == PH_FAST || s_q.ph == PH_SLOW) && zero_cur)
            s_d.zc = 1'b1;
        case (s_q.ph)
            PH_OFF, PH_BRAKE: begin
                if (!req_kept(s_q.ph, s_q.fwd, req_ph, dir_fwd)) begin
                    s_d.ph  = PH_DEAD;
                    s_d.tgt = req_ph;
                    s_d.fwd = dir_fwd;
                    s_d.cnt = C_DEAD;
                end
            end
            PH_DRIVE, PH_FAST, PH_SLOW: begin
                if (!req_kept(s_q.ph, s_q.fwd, req_ph, dir_fwd)) begin
                    s_d.ph  = PH_DEAD;
                    s_d.tgt = req_ph;
                    s_d.fwd = dir_fwd;
                    s_d.cnt = C_DEAD;
                end else if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.ph != PH_DRIVE || trip) begin
                    s_d.ph  = PH_DEAD;
                    s_d.cnt = C_DEAD;
                    case (s_q.ph)
                        PH_DRIVE: s_d.tgt = PH_FAST;
                        PH_FAST:  s_d.tgt = PH_SLOW;
                        default:  s_d.tgt = PH_DRIVE;
                    endcase
                end
            end
            PH_DEAD: begin
                if (!req_kept(s_q.tgt, s_q.fwd, req_ph, dir_fwd)) begin
                    s_d.tgt = req_ph;
                    s_d.fwd = dir_fwd;
                end
                if (s_q.cnt == '0) begin
                    s_d.ph  = s_d.tgt;
                    s_d.cnt = entry_count(s_d.tgt);
                    if (s_d.tgt == PH_DRIVE)
                        s_d.zc = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= ST_RESET;
        else
            s_q <= s_d;
    end

    chop_gate_map u_map (
        .ph     (s_q.ph),
        .fwd    (s_q.fwd),
        .zc_cut (s_q.zc),
        .gates  (gates)
    );

    assign {hs_a, ls_a, hs_b, ls_b} = gates;
    assign busy = (s_q.ph == PH_FAST) || (s_q.ph == PH_SLOW) ||
                  ((s_q.ph == PH_DEAD) &&
                   (s_q.tgt == PH_FAST || s_q.tgt == PH_SLOW));

endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hs_a,
    input logic ls_a,
    input logic hs_b,
    input logic ls_b,
    input logic busy,
    input logic zero_cur
);
    logic       seen_q;
    logic [3:0] g;

    assign g = {hs_a, ls_a, hs_b, ls_b};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else
            seen_q <= 1'b1;
    end

    AST_LEG_A_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a && ls_a)); // R11
    AST_LEG_B_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b && ls_b)); // R11
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (g == 4'b0000 && !busy)); // R1
    AST_GAP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && g != 4'b0000 && $past(g) != 4'b0000) |-> g == $past(g)); // R3
    AST_ZC_CUTS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && busy && ls_a && ls_b && zero_cur) |=> !(ls_a && ls_b)); // R8
    AST_BUSY_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(busy)) |-> g == 4'b0000); // R10
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_a     (hs_a),
    .ls_a     (ls_a),
    .hs_b     (hs_b),
    .ls_b     (ls_b),
    .busy     (busy),
    .zero_cur (zero_cur)
);

// File: tb/chop_ctrl_test.sv
module chop_ctrl_test;
    localparam int TD = 3;
    localparam int TB = 6;
    localparam int TO = 21;
    localparam int TF = TO / 2;
    localparam int TS = TO - TF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drive_en = 1'b0, brake_req = 1'b0, dir_fwd = 1'b1;
    logic trip = 1'b0, zero_cur = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b, busy;

    int n_tests = 0;
    int n_fail = 0;
    int cov[string];
    bit done = 1'b0;

    always #2 clk = ~clk;

    chop_ctrl #(.T_DEAD(TD), .T_BLANK(TB), .T_OFF(TO)) uut (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .brake_req(brake_req),
        .dir_fwd(dir_fwd), .trip(trip), .zero_cur(zero_cur),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .busy(busy)
    );

    // behavioural model: 0 coast, 1 brake, 2 drive, 3 fast, 4 slow, 5 gap
    int m_mode = 0, m_goal = 0, m_left = 0, m_blank = 0;
    bit m_fwd = 1'b0, m_zc = 1'b0, m_ign = 1'b0, m_abort = 1'b0;
    bit m_from_slow = 1'b0, m_rearm = 1'b0;

    function automatic int wanted();
        if (!drive_en) return 0;
        if (brake_req) return 1;
        return 2;
    endfunction

    function automatic bit satisfied(int md, bit f);
        if (md >= 2 && md <= 4) return wanted() == 2 && dir_fwd == f;
        return wanted() == md;
    endfunction

    task automatic enter(int g);
        m_mode = g;
        case (g)
            2: begin m_blank = TB; m_zc = 0; m_ign = 0;
                     m_rearm = m_from_slow; m_from_slow = 0; end
            3: m_left = TF;
            4: m_left = TS;
            default: ;
        endcase
    endtask

    task automatic to_gap(int g, bit ab);
        m_goal = g; m_mode = 5; m_left = TD; m_abort = ab;
    endtask

    task automatic model_step();
        if ((m_mode == 3 || m_mode == 4) && zero_cur) m_zc = 1;
        if (m_mode == 0 || m_mode == 1) begin
            if (!satisfied(m_mode, m_fwd)) begin
                m_fwd = dir_fwd; m_from_slow = 0; to_gap(wanted(), 0);
            end
        end else if (m_mode >= 2 && m_mode <= 4) begin
            if (!satisfied(m_mode, m_fwd)) begin
                m_fwd = dir_fwd; m_from_slow = 0; to_gap(wanted(), 1);
            end else if (m_mode == 2) begin
                if (m_blank > 0) begin
                    m_blank--; if (trip) m_ign = 1;
                end else if (trip) to_gap(3, 0);
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (m_mode == 4) m_from_slow = 1;
                    to_gap(m_mode == 3 ? 4 : 2, 0);
                end
            end
        end else begin
            if (!satisfied(m_goal, m_fwd)) begin
                m_goal = wanted(); m_fwd = dir_fwd; m_abort = 1; m_from_slow = 0;
            end
            m_left--;
            if (m_left == 0) enter(m_goal);
        end
    endtask

    function automatic logic [3:0] exp_gates();
        case (m_mode)
            1: return 4'b0101;
            2: return m_fwd ? 4'b1001 : 4'b0110;
            3: return m_zc ? 4'b0000 : (m_fwd ? 4'b0110 : 4'b1001);
            4: return m_zc ? 4'b0000 : 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic bit exp_busy();
        return m_mode == 3 || m_mode == 4 || (m_mode == 5 && (m_goal == 3 || m_goal == 4));
    endfunction

    function automatic string pat_tag();
        if (m_mode == 5) return m_abort ? "R9" : "R3";
        if ((m_mode == 3 || m_mode == 4) && m_zc) return "R8";
        if (m_mode == 3) return "R5";
        if (m_mode == 4) return "R6";
        if (m_mode == 2 && m_ign) return "R4";
        if (m_mode == 2 && m_rearm) return "R7";
        return "R2";
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (cov.exists(tag)) cov[tag]++; else cov[tag] = 1;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_goal = 0; m_left = 0; m_blank = 0; m_fwd = 0;
            m_zc = 0; m_ign = 0; m_abort = 0; m_from_slow = 0; m_rearm = 0;
        end else begin
            model_step();
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk({hs_a, ls_a, hs_b, ls_b, busy} == 5'b0, "R1",
                    {hs_a, ls_a, hs_b, ls_b, busy}, 0);
            end else begin
                chk({hs_a, ls_a, hs_b, ls_b} == exp_gates(), pat_tag(),
                    {hs_a, ls_a, hs_b, ls_b}, exp_gates());
                chk(busy == exp_busy(), "R10", busy, exp_busy());
                chk(!(hs_a && ls_a) && !(hs_b && ls_b), "R11",
                    {hs_a, ls_a, hs_b, ls_b}, 0);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        string tags[11] = '{"R1", "R2", "R3", "R4", "R5", "R6",
                            "R7", "R8", "R9", "R10", "R11"};
        done = 1'b1;
        foreach (tags[i]) begin
            n_tests++;
            if (!cov.exists(tags[i])) begin
                n_fail++;
                $display("FAIL %s: actual 0 expected >0 exercised cycles", tags[i]);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);                                  // coast hold, R2
        // continuous chopping forward with trip held high: R4 R5 R6 R7
        drive_en = 1; dir_fwd = 1; trip = 1;
        wait_cyc(90);
        // zero-current pulses at a period coprime to the chop period: R8
        for (int c = 0; c < 120; c++) begin
            zero_cur = (c % 7 == 3);
            wait_cyc(1);
        end
        zero_cur = 0;
        // request change swept across every offset of a chop cycle: R9
        for (int kind = 0; kind < 3; kind++) begin
            for (int k = 0; k < TD + TB + TO + 2 * TD + 4; k++) begin
                drive_en = 0; brake_req = 0; trip = 0; dir_fwd = kind[0];
                wait_cyc(TD + 2);
                drive_en = 1; trip = 1;
                wait_cyc(k);
                case (kind)
                    0: brake_req = 1;
                    1: dir_fwd = ~dir_fwd;
                    default: drive_en = 0;
                endcase
                wait_cyc(TD + TB + 4);
                brake_req = 0; drive_en = 1;
                wait_cyc(2);
            end
        end
        // one-cycle request blip inside the crossover gap: retarget, R9
        drive_en = 1; brake_req = 0; trip = 0; dir_fwd = 1;
        wait_cyc(TD + TB + 2);
        brake_req = 1; wait_cyc(1); brake_req = 0;
        wait_cyc(TD + 4);
        // trip pulse swept across the blanking boundary: R4 R5
        for (int j = 0; j < TD + TB + 4; j++) begin
            drive_en = 0; trip = 0; dir_fwd = j[0];
            wait_cyc(TD + 2);
            drive_en = 1;
            wait_cyc(j);
            trip = 1; wait_cyc(1); trip = 0;
            wait_cyc(TD + TO + 3 * TD + 4);
        end
        drive_en = 0;
        wait_cyc(TD + 3);
        finish_run();
    end
endmodule